// File: doc/BRIEF.md
# Transmit Descriptor Queue Engine

This block works through a ring of transmit descriptors kept in a byte-wide buffer memory. Each descriptor takes eight bytes. One status byte in each descriptor tells whether software or hardware owns the entry. FFh means software has built the frame and it is ready to send. 00h means the engine has claimed the frame. Any other value means the frame is finished.

The host sets a pending flag. While that flag is set and the device is online, the engine reads the status of the current entry. For a ready entry it reads the frame start address and byte count, writes 00h over the status to claim the entry, and starts the transmitter. When the transmitter reports done, the engine writes the final status and the collision count back into the entry. It then moves to the next entry in the ring.

The first entry that is not ready ends the chain. The engine leaves that entry untouched, clears the pending flag and raises a transmit-complete interrupt. Setting the pending flag again resumes the scan from that same entry. A stop command lets the current frame finish, then halts the engine and reports a stopped status.

Top module: `txq_engine`

## Requirements
- R1: While reset is asserted and right after it is released, the engine makes no memory request, does not pulse `tx_start_o`, keeps `irq_status_o` at 0 and keeps `irq_o` low.
- R2: With `online_i` low, a pending command causes no memory access. The pending state is kept, and scanning starts once `online_i` goes high.
- R3: The status byte sits at offset 1 of an entry, and FFh there marks the entry ready. For a ready entry the engine reads offsets 2..5 as start address low, start address high, count low and count high. It then writes 00h to offset 1, and this write completes in the cycle just before `tx_start_o` is raised.
- R4: `tx_start_o` is high for exactly one cycle. In that cycle `tx_addr_o` and `tx_len_o` show the 16-bit values assembled from the descriptor, low byte first.
- R5: After `tx_done_i`, the engine writes `tx_status_i` to offset 1 and the zero-extended `tx_coll_i` to offset 0 of the same entry.
- R6: When the status byte is not FFh, the engine starts no transmission, leaves that byte as it is, sets interrupt bit 0 (transmit complete) and makes no further memory access until a new command arrives.
- R7: Entry addresses are the base plus 8 times the index. After the last of `NUM_ENTRIES` entries, the index wraps to the base.
- R8: A pending command after a halt resumes the scan from the entry where the engine halted, and sets bit 0 again when that new chain ends.
- R9: A stop command lets the frame in progress finish its write-back. The engine then claims no further entry and sets interrupt bit 1 (stopped), leaving bit 0 clear.
- R10: Each interrupt status bit stays set until a one is written to its bit of `irq_clr_i`. `irq_o` is the OR of the status bits gated by `irq_mask_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| online_i | input | 1 | Device online; scanning is allowed only while high |
| cmd_txp_i | input | 1 | Pulse: set transmit pending |
| cmd_stp_i | input | 1 | Pulse: request stop |
| base_addr_i | input | AW | Ring base address |
| irq_clr_i | input | 2 | Write-one-to-clear of the interrupt status bits |
| irq_mask_i | input | 2 | Interrupt enable per status bit |
| irq_status_o | output | 2 | Bit 0 transmit complete, bit 1 stopped |
| irq_o | output | 1 | Masked interrupt |
| mem_req_o | output | 1 | Memory access request, held until acknowledged |
| mem_we_o | output | 1 | Write access |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_ack_i | input | 1 | Access complete; read data valid |
| mem_rdata_i | input | 8 | Read data |
| tx_start_o | output | 1 | One-cycle transmit start |
| tx_addr_o | output | 16 | Frame start address |
| tx_len_o | output | 16 | Frame byte count |
| tx_done_i | input | 1 | Transmit done pulse |
| tx_status_i | input | 8 | Final transmit status |
| tx_coll_i | input | COLL_W | Collision count |

## Verification
The scan is run on several chains:

- **Three ready frames ended by a foreign status byte.** This separates correct chain termination from scanning past the end.
- **A later append that runs across the ring boundary.** This shows a resume from the halted entry instead of from the base, and it shows the wrap.
- **A stop issued while a slow frame is in flight.** This separates finishing the current frame from claiming the next one.
- **A first kick while offline.** This shows that the pending state is held instead of acted on.

Each frame has its own address, length, status and collision values, so a mixed-up byte order or the wrong entry in a write-back shows up as a mismatch.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int unsigned DESC_BYTES   = 8;
  localparam int unsigned DESC_SHIFT   = 3;
  localparam logic [2:0]  OFF_COLL     = 3'd0;
  localparam logic [2:0]  OFF_STAT     = 3'd1;
  localparam logic [2:0]  OFF_FIELDS   = 3'd2;
  localparam logic [7:0]  STAT_READY   = 8'hFF;
  localparam logic [7:0]  STAT_CLAIMED = 8'h00;
  localparam int unsigned IRQ_TXC      = 0;
  localparam int unsigned IRQ_STOP     = 1;
  localparam int unsigned IRQ_N        = 2;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SCAN,
    S_RD_STAT,
    S_RD_DESC,
    S_WR_CLAIM,
    S_TX_START,
    S_TX_WAIT,
    S_WR_STAT,
    S_WR_COLL
  } txq_state_e;
endpackage

// File: rtl/txq_ring_ptr.sv
module txq_ring_ptr #(
  parameter int unsigned AW          = 16,
  parameter int unsigned NUM_ENTRIES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic          adv_i,
  output logic [AW-1:0] entry_addr_o
);
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         idx_q <= '0;
    else if (adv_i)      idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  assign entry_addr_o = base_i + (AW'(idx_q) << txq_pkg::DESC_SHIFT);
endmodule

// File: rtl/txq_irq_ctrl.sv
module txq_irq_ctrl #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        status_o[g] <= 1'b0;
      else if (set_i[g])  status_o[g] <= 1'b1;  // set wins over clear
      else if (clr_i[g])  status_o[g] <= 1'b0;
    end
  end

  assign irq_o = |(status_o & mask_i);
endmodule

// File: rtl/txq_engine.sv
module txq_engine
  import txq_pkg::*;
#(
  parameter int unsigned AW          = 16,
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned COLL_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              online_i,
  input  logic              cmd_txp_i,
  input  logic              cmd_stp_i,
  input  logic [AW-1:0]     base_addr_i,
  input  logic [1:0]        irq_clr_i,
  input  logic [1:0]        irq_mask_i,
  output logic [1:0]        irq_status_o,
  output logic              irq_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              tx_start_o,
  output logic [15:0]       tx_addr_o,
  output logic [15:0]       tx_len_o,
  input  logic              tx_done_i,
  input  logic [7:0]        tx_status_i,
  input  logic [COLL_W-1:0] tx_coll_i
);
  txq_state_e        state_q;
  logic              txp_q, stp_q;
  logic [1:0]        fld_q;
  logic [15:0]       addr_q, len_q;
  logic [7:0]        tstat_q;
  logic [COLL_W-1:0] coll_q;
  logic [AW-1:0]     entry_addr;
  logic [2:0]        off;
  logic              txc_set, stop_set, adv;
  logic [IRQ_N-1:0]  irq_set;

  txq_ring_ptr #(.AW(AW), .NUM_ENTRIES(NUM_ENTRIES)) u_ptr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .base_i       (base_addr_i),
    .adv_i        (adv),
    .entry_addr_o (entry_addr)
  );

  assign txc_set  = (state_q == S_RD_STAT) && mem_ack_i && (mem_rdata_i != STAT_READY);
  assign stop_set = (state_q == S_SCAN) && stp_q;
  assign adv      = (state_q == S_WR_COLL) && mem_ack_i;

  always_comb begin
    irq_set           = '0;
    irq_set[IRQ_TXC]  = txc_set;
    irq_set[IRQ_STOP] = stop_set;
  end

  txq_irq_ctrl #(.N(IRQ_N)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (irq_set),
    .clr_i    (irq_clr_i),
    .mask_i   (irq_mask_i),
    .status_o (irq_status_o),
    .irq_o    (irq_o)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    off         = OFF_STAT;
    mem_wdata_o = '0;
    unique case (state_q)
      S_RD_STAT:  mem_req_o = 1'b1;
      S_RD_DESC: begin
        mem_req_o = 1'b1;
        off       = OFF_FIELDS + {1'b0, fld_q};
      end
      S_WR_CLAIM: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = STAT_CLAIMED;
      end
      S_WR_STAT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = tstat_q;
      end
      S_WR_COLL: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        off         = OFF_COLL;
        mem_wdata_o = 8'(coll_q);
      end
      default: ;
    endcase
  end

  assign mem_addr_o = entry_addr + AW'(off);
  assign tx_start_o = (state_q == S_TX_START);
  assign tx_addr_o  = addr_q;
  assign tx_len_o   = len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txp_q <= 1'b0;
      stp_q <= 1'b0;
    end else begin
      if (cmd_txp_i)                   txp_q <= 1'b1;
      else if (txc_set || stop_set)    txp_q <= 1'b0;
      if (cmd_stp_i)                   stp_q <= 1'b1;
      else if (stop_set)               stp_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      fld_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      tstat_q <= '0;
      coll_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (txp_q || stp_q) state_q <= S_SCAN;
        S_SCAN: begin
          if (stp_q || !txp_q) state_q <= S_IDLE;
          else if (online_i)   state_q <= S_RD_STAT;
        end
        S_RD_STAT: if (mem_ack_i) begin
          fld_q   <= '0;
          state_q <= (mem_rdata_i == STAT_READY) ? S_RD_DESC : S_IDLE;
        end
        S_RD_DESC: if (mem_ack_i) begin
          unique case (fld_q)
            2'd0: addr_q[7:0]  <= mem_rdata_i;
            2'd1: addr_q[15:8] <= mem_rdata_i;
            2'd2: len_q[7:0]   <= mem_rdata_i;
            default: len_q[15:8] <= mem_rdata_i;
          endcase
          fld_q <= fld_q + 2'd1;
          if (fld_q == 2'd3) state_q <= S_WR_CLAIM;
        end
        S_WR_CLAIM: if (mem_ack_i) state_q <= S_TX_START;
        S_TX_START: state_q <= S_TX_WAIT;
        S_TX_WAIT: if (tx_done_i) begin
          tstat_q <= tx_status_i;
          coll_q  <= tx_coll_i;
          state_q <= S_WR_STAT;
        end
        S_WR_STAT: if (mem_ack_i) state_q <= S_WR_COLL;
        S_WR_COLL: if (mem_ack_i) state_q <= S_SCAN;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txq_engine_chk.sv
module txq_engine_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_ack_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [7:0]    mem_wdata_o,
  input logic          tx_start_o,
  input logic [1:0]    irq_clr_i,
  input logic [1:0]    irq_mask_i,
  input logic [1:0]    irq_status_o,
  input logic          irq_o
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o); // R4
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R3
  AST_CLAIM_BEFORE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> $past(mem_req_o && mem_we_o && mem_ack_i && (mem_wdata_o == 8'h00))); // R3
  AST_TXC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_status_o[0] && !irq_clr_i[0]) |=> irq_status_o[0]); // R10
  AST_STOP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_status_o[1] && !irq_clr_i[1]) |=> irq_status_o[1]); // R9
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_mask_i == 2'b00) |-> !irq_o); // R10
endmodule

bind txq_engine txq_engine_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_ack_i    (mem_ack_i),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .tx_start_o   (tx_start_o),
  .irq_clr_i    (irq_clr_i),
  .irq_mask_i   (irq_mask_i),
  .irq_status_o (irq_status_o),
  .irq_o        (irq_o)
);

// File: tb/txq_engine_bench.sv
`timescale 1ns/1ps
module txq_engine_bench;
  typedef struct packed {
    logic [15:0] a;
    logic [15:0] l;
    logic [7:0]  s;
    logic [3:0]  c;
  } vec_t;

  // frame i goes to entry i % 4
  localparam vec_t VEC [7] = '{
    '{16'h1234, 16'h0040, 8'h01, 4'h0},
    '{16'hA5C3, 16'h05EE, 8'h03, 4'h2},
    '{16'h0F0E, 16'h0101, 8'h11, 4'hF},
    '{16'h8001, 16'h003C, 8'h21, 4'h1},
    '{16'h7E55, 16'hFF00, 8'h41, 4'h7},
    '{16'h2468, 16'h0200, 8'h07, 4'h3},
    '{16'h9BDF, 16'h1357, 8'h13, 4'hA}
  };
  localparam logic [15:0] BASE = 16'h0040;

  logic clk = 1'b0, rst_n = 1'b0;
  logic online = 1'b0, cmd_txp = 1'b0, cmd_stp = 1'b0;
  logic [1:0] irq_clr = 2'b00, irq_mask = 2'b00, irq_status;
  logic irq;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = 8'h00;
  logic tx_start, tx_done = 1'b0;
  logic [15:0] tx_addr, tx_len;
  logic [7:0] tx_stat = 8'h00;
  logic [3:0] tx_coll = 4'h0;

  logic [7:0] mem [256];
  logic tb_we = 1'b0;
  logic [7:0] tb_addr = 8'h00, tb_data = 8'h00;

  int checks = 0, errors = 0;
  int n_tx = 0, req_cycles = 0, claim_cnt = 0, start_run = 0, start_run_max = 0;
  int tx_delay = 3, tx_cnt = 0;
  logic tx_busy = 1'b0;
  logic [15:0] cap_a [8];
  logic [15:0] cap_l [8];

  always #2.5 clk = ~clk;

  txq_engine u_txq_engine (
    .clk_i(clk), .rst_ni(rst_n), .online_i(online), .cmd_txp_i(cmd_txp), .cmd_stp_i(cmd_stp),
    .base_addr_i(BASE), .irq_clr_i(irq_clr), .irq_mask_i(irq_mask), .irq_status_o(irq_status),
    .irq_o(irq), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .tx_start_o(tx_start), .tx_addr_o(tx_addr), .tx_len_o(tx_len), .tx_done_i(tx_done),
    .tx_status_i(tx_stat), .tx_coll_i(tx_coll)
  );

  // buffer memory: one-cycle acknowledge
  always @(posedge clk) begin
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && !mem_ack) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:0]];
    end
    if (tb_we) mem[tb_addr] <= tb_data;
  end

  // transmitter model and monitors
  always @(posedge clk) begin
    tx_done <= 1'b0;
    if (mem_req) req_cycles <= req_cycles + 1;
    if (mem_req && mem_ack && mem_we && mem_wdata == 8'h00 && mem_addr[2:0] == 3'd1)
      claim_cnt <= claim_cnt + 1;
    if (tx_start) begin
      start_run <= start_run + 1;
      if (start_run + 1 > start_run_max) start_run_max <= start_run + 1;
    end else start_run <= 0;
    if (tx_start) begin
      cap_a[n_tx % 8] <= tx_addr;
      cap_l[n_tx % 8] <= tx_len;
      n_tx    <= n_tx + 1;
      tx_busy <= 1'b1;
      tx_cnt  <= tx_delay;
    end else if (tx_busy) begin
      if (tx_cnt == 0) begin
        tx_busy <= 1'b0;
        tx_done <= 1'b1;
        tx_stat <= VEC[(n_tx - 1) % 7].s;
        tx_coll <= VEC[(n_tx - 1) % 7].c;
      end else tx_cnt <= tx_cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); tb_we = 1'b1; tb_addr = a; tb_data = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  task automatic prep(input int ent, input int v);
    logic [7:0] b;
    b = BASE[7:0] + 8'(ent * 8);
    wr_byte(b + 8'd0, 8'hEE);
    wr_byte(b + 8'd2, VEC[v].a[7:0]);
    wr_byte(b + 8'd3, VEC[v].a[15:8]);
    wr_byte(b + 8'd4, VEC[v].l[7:0]);
    wr_byte(b + 8'd5, VEC[v].l[15:8]);
    wr_byte(b + 8'd6, 8'h00);
    wr_byte(b + 8'd1, 8'hFF);
  endtask

  task automatic pulse_txp();
    @(negedge clk); cmd_txp = 1'b1; @(negedge clk); cmd_txp = 1'b0;
  endtask

  task automatic wait_irq(input int bitn, input string req);
    int n = 0;
    while (!irq_status[bitn] && n < 2000) begin @(negedge clk); n++; end
    chk(irq_status[bitn], req, 0, 1);
  endtask

  function automatic logic [7:0] eb(input int ent, input int off);
    return mem[BASE[7:0] + 8'(ent * 8 + off)];
  endfunction

  initial begin
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r;
    repeat (3) @(negedge clk);
    chk(!mem_req && !tx_start && irq_status == 2'b00 && !irq, "R1 in reset", irq_status, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!mem_req && !tx_start && irq_status == 2'b00 && !irq, "R1 after reset", irq_status, 0);

    // chain 1: entries 0..2 ready, entry 3 foreign status
    for (int e = 0; e < 3; e++) prep(e, e);
    wr_byte(BASE[7:0] + 8'd25, 8'h5A);
    pulse_txp();
    repeat (30) @(negedge clk);
    chk(req_cycles == 0, "R2 offline no access", req_cycles, 0);
    chk(n_tx == 0, "R2 offline no start", n_tx, 0);
    online = 1'b1;
    wait_irq(0, "R6 txc after chain 1");
    chk(n_tx == 3, "R6 frames in chain 1", n_tx, 3);
    chk(claim_cnt == 3, "R3 claim writes", claim_cnt, 3);
    chk(start_run_max == 1, "R4 start width", start_run_max, 1);
    chk(eb(3, 1) == 8'h5A, "R6 end entry untouched", eb(3, 1), 8'h5A);
    for (int e = 0; e < 3; e++) begin
      chk(eb(e, 1) == VEC[e].s, "R5 status write-back", eb(e, 1), VEC[e].s);
      chk(eb(e, 0) == {4'h0, VEC[e].c}, "R5 collision write-back", eb(e, 0), VEC[e].c);
    end
    r = req_cycles;
    repeat (20) @(negedge clk);
    chk(req_cycles == r, "R6 halted quiet", req_cycles, r);

    // interrupt mask and clear
    chk(!irq, "R10 masked", irq, 0);
    irq_mask = 2'b01; @(negedge clk);
    chk(irq, "R10 unmasked", irq, 1);
    irq_clr = 2'b01; @(negedge clk); irq_clr = 2'b00; @(negedge clk);
    chk(irq_status == 2'b00 && !irq, "R10 w1c", irq_status, 0);

    // chain 2: append entry 3 and wrap to entry 0
    prep(3, 3);
    prep(0, 4);
    pulse_txp();
    wait_irq(0, "R8 second txc");
    chk(n_tx == 5, "R8 frames in chain 2", n_tx, 5);
    chk(eb(1, 1) == VEC[1].s, "R7 end after wrap untouched", eb(1, 1), VEC[1].s);
    irq_clr = 2'b01; @(negedge clk); irq_clr = 2'b00;

    // stop while a slow frame is in flight
    tx_delay = 20;
    prep(1, 5);
    prep(2, 6);
    pulse_txp();
    r = 0;
    while (n_tx < 6 && r < 2000) begin @(negedge clk); r++; end
    cmd_stp = 1'b1; @(negedge clk); cmd_stp = 1'b0;
    wait_irq(1, "R9 stopped status");
    chk(n_tx == 6, "R9 no further claim", n_tx, 6);
    chk(eb(1, 1) == VEC[5].s, "R9 frame finished", eb(1, 1), VEC[5].s);
    chk(eb(2, 1) == 8'hFF, "R9 next entry left ready", eb(2, 1), 8'hFF);
    chk(irq_status[0] == 1'b0, "R9 no txc on stop", irq_status, 2);
    tx_delay = 3;
    pulse_txp();
    wait_irq(0, "R8 resume after stop");
    chk(n_tx == 7, "R8 frames after resume", n_tx, 7);

    // vector walk: every frame's fields and final write-back
    for (int i = 0; i < 7; i++) begin
      chk(cap_a[i] == VEC[i].a, "R4 frame address", cap_a[i], VEC[i].a);
      chk(cap_l[i] == VEC[i].l, "R4 frame length", cap_l[i], VEC[i].l);
      if (i >= 3) begin
        chk(eb(i % 4, 1) == VEC[i].s, "R7 ring entry status", eb(i % 4, 1), VEC[i].s);
        chk(eb(i % 4, 0) == {4'h0, VEC[i].c}, "R5 ring entry collisions", eb(i % 4, 0), VEC[i].c);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule